// File: doc/BRIEF.md
# Pulse-Skipping Overcurrent Protection Sequencer

This block carries out the cycle-counted overcurrent response of a synchronous buck controller. Once per switching cycle, at the end of the low-side conduction interval, a one-clock tick samples an already synchronized overcurrent comparator flag. A sampled trip stops the high-side switch from turning on in the following switching cycle, so the converter skips pulses while the current stays above the limit.

The first trip starts a sixteen-cycle sequence made of two equal windows. Trips in the first window only keep the pulse skipping going. A trip in the second window latches a shutdown that holds the high-side switch off and pulls power-good low. If the second window passes without a trip, the sequence clears itself and a later trip starts a new one. The latch is released only when the enable input or the supply-good input goes low. The window length is a parameter, eight cycles by default.

Top module: `ocp_pulse_skip_latch`

## Requirements
- R1: After reset, hs_inhibit, oc_shutdown, pgood_pull_low, win_first and win_second are all low.
- R2: While running and not shut down, a clock with cyc_tick high and oc_flag high sets hs_inhibit from the next clock on. A tick with oc_flag low clears it from the next clock on.
- R3: When cyc_tick is low, oc_flag has no effect. hs_inhibit, oc_shutdown and the window outputs keep their values.
- R4: A tick with oc_flag high while idle (the first trip) starts the sequence. Counting later ticks from that trip, win_first is high after the trip tick and after ticks 1 to 7. win_second is high after ticks 8 to 15. Both are low while idle or shut down, and they are never high together.
- R5: A trip at any of ticks 1 to 8 after the first trip does not latch and does not restart the count. Its only effect is to extend pulse skipping.
- R6: A trip at any of ticks 9 to 16 after the first trip sets oc_shutdown, pgood_pull_low and hs_inhibit from the next clock.
- R7: If ticks 9 to 16 carry no trip, the sequence ends at tick 16. Both windows go low, no shutdown is set, and the next trip starts a fresh sequence.
- R8: Once set, oc_shutdown stays set whatever cyc_tick and oc_flag do, for as long as enable and supply_ok are both high. While either of them is low, the latch, the count and the inhibit are cleared from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse at the end of each low-side conduction interval |
| oc_flag | input | 1 | Synchronized overcurrent comparator output, sampled on cyc_tick |
| enable | input | 1 | Device enable; low clears the sequence and the latch |
| supply_ok | input | 1 | Supply above its undervoltage limit; low clears like enable |
| hs_inhibit | output | 1 | High: the high-side switch must not turn on (pulse skipped) |
| oc_shutdown | output | 1 | Latched overcurrent shutdown |
| pgood_pull_low | output | 1 | High: force power-good low |
| win_first | output | 1 | Sequence is in its first window |
| win_second | output | 1 | Sequence is in its second window |

## Verification
The bench places trips on the last tick of the first window (tick 8) and on the first and last ticks of the second window (ticks 9 and 16). An off-by-one window decode would latch too early or fail to latch at the edges. It toggles oc_flag between ticks, which a design sampling every clock would turn into stray skips or windows. It also starts a new trip on the tick right after a sequence ends, where a counter that does not return cleanly to idle would resume an old count. It drops enable and supply_ok both in the middle of a sequence and with the latch set, where a design that does not clear all its state would leave the shutdown or the windows stuck.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

   // Sequence state of the overcurrent protection controller
   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_COUNT   = 2'd1,
      SEQ_LATCHED = 2'd2
   } seq_state_e;

endpackage

// File: rtl/ocp_cycle_counter.sv
module ocp_cycle_counter #(
   parameter int unsigned WIN_CYCLES = 8,
   parameter int unsigned CNT_W      = $clog2(2 * WIN_CYCLES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic start_i,
   input  logic advance_i,
   output logic in_second_o,
   output logic at_last_o
);

   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(2 * WIN_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i || start_i) begin
         cnt_q <= '0;
      end else if (advance_i) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // Window decode: a single bit when the window is a power of two
   if ((WIN_CYCLES & (WIN_CYCLES - 1)) == 0) begin : g_pow2_decode
      assign in_second_o = cnt_q[CNT_W-1];
   end else begin : g_cmp_decode
      localparam logic [CNT_W-1:0] SECOND_START = CNT_W'(WIN_CYCLES);
      assign in_second_o = (cnt_q >= SECOND_START);
   end

   assign at_last_o = (cnt_q == LAST_CNT);

endmodule

// File: rtl/ocp_trip_seq.sv
module ocp_trip_seq
   import ocp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   input  logic       tick_i,
   input  logic       trip_i,
   input  logic       in_second_i,
   input  logic       at_last_i,
   output seq_state_e state_o,
   output logic       start_o,
   output logic       advance_o,
   output logic       clear_o
);

   seq_state_e state_q, state_d;

   always_comb begin
      state_d   = state_q;
      start_o   = 1'b0;
      advance_o = 1'b0;
      clear_o   = 1'b0;
      if (!run_i) begin
         state_d = SEQ_IDLE;
         clear_o = 1'b1;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (tick_i && trip_i) begin
                  state_d = SEQ_COUNT;
                  start_o = 1'b1;
               end
            end
            SEQ_COUNT: begin
               if (tick_i) begin
                  if (trip_i && in_second_i) begin
                     state_d = SEQ_LATCHED;
                  end else if (at_last_i) begin
                     state_d = SEQ_IDLE;
                     clear_o = 1'b1;
                  end else begin
                     advance_o = 1'b1;
                  end
               end
            end
            SEQ_LATCHED: begin
               state_d = SEQ_LATCHED;
            end
            default: begin
               state_d = SEQ_IDLE;
               clear_o = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/ocp_skip_gate.sv
module ocp_skip_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   input  logic trip_i,
   input  logic latched_i,
   output logic inhibit_o
);

   logic skip_q;

   // The sampled flag governs the following switching cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         skip_q <= 1'b0;
      end else if (!run_i) begin
         skip_q <= 1'b0;
      end else if (tick_i) begin
         skip_q <= trip_i;
      end
   end

   assign inhibit_o = skip_q | latched_i;

endmodule

// File: rtl/ocp_pulse_skip_latch.sv
module ocp_pulse_skip_latch
   import ocp_pkg::*;
#(
   parameter int unsigned WIN_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_tick,
   input  logic oc_flag,
   input  logic enable,
   input  logic supply_ok,
   output logic hs_inhibit,
   output logic oc_shutdown,
   output logic pgood_pull_low,
   output logic win_first,
   output logic win_second
);

   localparam int unsigned CNT_W = $clog2(2 * WIN_CYCLES);

   if (WIN_CYCLES < 2) begin : g_bad_window
      $error("WIN_CYCLES must be at least 2");
   end

   logic       run;
   logic       start, advance, clear_cnt;
   logic       in_second, at_last;
   seq_state_e state;
   logic       latched;

   assign run = enable & supply_ok;

   ocp_cycle_counter #(
      .WIN_CYCLES (WIN_CYCLES),
      .CNT_W      (CNT_W)
   ) cnt_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (clear_cnt),
      .start_i     (start),
      .advance_i   (advance),
      .in_second_o (in_second),
      .at_last_o   (at_last)
   );

   ocp_trip_seq seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run),
      .tick_i      (cyc_tick),
      .trip_i      (oc_flag),
      .in_second_i (in_second),
      .at_last_i   (at_last),
      .state_o     (state),
      .start_o     (start),
      .advance_o   (advance),
      .clear_o     (clear_cnt)
   );

   assign latched = (state == SEQ_LATCHED);

   ocp_skip_gate skip_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .tick_i    (cyc_tick),
      .trip_i    (oc_flag),
      .latched_i (latched),
      .inhibit_o (hs_inhibit)
   );

   assign oc_shutdown    = latched;
   assign pgood_pull_low = latched;
   assign win_first      = (state == SEQ_COUNT) & ~in_second;
   assign win_second     = (state == SEQ_COUNT) & in_second;

endmodule

// File: rtl/ocp_pulse_skip_latch_chk.sv
module ocp_pulse_skip_latch_chk (
   input logic clk,
   input logic rst_n,
   input logic cyc_tick,
   input logic oc_flag,
   input logic enable,
   input logic supply_ok,
   input logic hs_inhibit,
   input logic oc_shutdown,
   input logic pgood_pull_low,
   input logic win_first,
   input logic win_second
);

   logic run;
   assign run = enable & supply_ok;

   // R2
   trip_sets_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cyc_tick && oc_flag) |=> hs_inhibit);

   // R3
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cyc_tick) |=> ($stable(hs_inhibit) && $stable(oc_shutdown)
                              && $stable(win_first) && $stable(win_second)));

   // R4
   window_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({win_first, win_second, oc_shutdown}));

   // R5
   first_win_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && win_first && cyc_tick) |=> !oc_shutdown);

   // R6
   second_win_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && win_second && cyc_tick && oc_flag) |=> oc_shutdown);

   // R6
   latch_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oc_shutdown |-> (hs_inhibit && pgood_pull_low));

   // R8
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && oc_shutdown) |=> oc_shutdown);

   // R8
   stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!oc_shutdown && !hs_inhibit && !win_first && !win_second));

endmodule

bind ocp_pulse_skip_latch ocp_pulse_skip_latch_chk chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .cyc_tick       (cyc_tick),
   .oc_flag        (oc_flag),
   .enable         (enable),
   .supply_ok      (supply_ok),
   .hs_inhibit     (hs_inhibit),
   .oc_shutdown    (oc_shutdown),
   .pgood_pull_low (pgood_pull_low),
   .win_first      (win_first),
   .win_second     (win_second)
);

// File: tb/ocp_pulse_skip_latch_tb_top.sv
`timescale 1ns/1ps
module ocp_pulse_skip_latch_tb_top;

   localparam int WIN = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_tick = 1'b0;
   logic oc_flag = 1'b0;
   logic enable = 1'b1;
   logic supply_ok = 1'b1;
   logic hs_inhibit, oc_shutdown, pgood_pull_low, win_first, win_second;

   int total = 0;
   int bad = 0;
   bit cmp_on = 0;
   bit done = 0;

   // reference model state
   int k = -1;
   bit m_shut = 0;
   bit m_skip = 0;

   always #5 clk = ~clk;

   ocp_pulse_skip_latch #(.WIN_CYCLES(WIN)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cyc_tick       (cyc_tick),
      .oc_flag        (oc_flag),
      .enable         (enable),
      .supply_ok      (supply_ok),
      .hs_inhibit     (hs_inhibit),
      .oc_shutdown    (oc_shutdown),
      .pgood_pull_low (pgood_pull_low),
      .win_first      (win_first),
      .win_second     (win_second)
   );

   task automatic chk(input string req, input string what, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, got, exp, $time);
      end
   endtask

   // behavioural reference, updated at each rising edge
   always @(posedge clk) begin
      if (!rst_n || !(enable && supply_ok)) begin
         k = -1; m_shut = 0; m_skip = 0;
      end else if (!m_shut && cyc_tick) begin
         m_skip = oc_flag;
         if (k < 0) begin
            if (oc_flag) k = 0;
         end else begin
            k++;
            if (oc_flag && k > WIN) begin
               m_shut = 1; k = -1;
            end else if (k == 2 * WIN) begin
               k = -1;
            end
         end
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R2", "hs_inhibit", hs_inhibit, m_skip | m_shut);
         chk("R6", "oc_shutdown", oc_shutdown, m_shut);
         chk("R6", "pgood_pull_low", pgood_pull_low, m_shut);
         chk("R4", "win_first", win_first, (k >= 0) && (k < WIN));
         chk("R4", "win_second", win_second, (k >= WIN) && (k < 2 * WIN));
      end
   end

   task automatic do_tick(input logic oc, input int gap);
      @(negedge clk); cyc_tick = 1'b1; oc_flag = oc;
      @(negedge clk); cyc_tick = 1'b0; oc_flag = ~oc;
      for (int g = 0; g < gap; g++) begin
         @(negedge clk); oc_flag = ~oc_flag;
      end
      @(negedge clk); oc_flag = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1;
      settle();
      // R1
      chk("R1", "hs_inhibit", hs_inhibit, 1'b0);
      chk("R1", "oc_shutdown", oc_shutdown, 1'b0);
      chk("R1", "pgood_pull_low", pgood_pull_low, 1'b0);
      chk("R1", "windows", win_first | win_second, 1'b0);

      // R3: flag activity between ticks only
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); oc_flag = ~oc_flag;
      end
      @(negedge clk); oc_flag = 1'b0; settle();
      chk("R3", "hs_inhibit", hs_inhibit, 1'b0);
      chk("R3", "win_first", win_first, 1'b0);
      do_tick(1'b0, 2);

      // R4 / R7: clean sequence
      do_tick(1'b1, 2);
      chk("R4", "win_first after trip", win_first, 1'b1);
      chk("R2", "hs_inhibit after trip", hs_inhibit, 1'b1);
      for (int i = 1; i <= 2 * WIN; i++) begin
         do_tick(1'b0, 1 + (i % 3));
         if (i < WIN) chk("R4", "win_first", win_first, 1'b1);
         else if (i < 2 * WIN) chk("R4", "win_second", win_second, 1'b1);
      end
      chk("R7", "win_second at end", win_second, 1'b0);
      chk("R7", "oc_shutdown at end", oc_shutdown, 1'b0);

      // R7: immediate new trip; R5: trips in first window
      do_tick(1'b1, 1);
      chk("R7", "fresh win_first", win_first, 1'b1);
      for (int i = 1; i <= 2 * WIN; i++) begin
         do_tick((i == 3) || (i == WIN), 1);
         if (i == 3) chk("R5", "skip extended", hs_inhibit, 1'b1);
         if (i == 4) chk("R2", "skip cleared", hs_inhibit, 1'b0);
         if (i == WIN) begin
            chk("R5", "no latch at tick 8", oc_shutdown, 1'b0);
            chk("R5", "no restart", win_second, 1'b1);
         end
      end
      chk("R7", "idle after clean second window", win_first | win_second, 1'b0);

      // R6: trip on tick 9; R8 hold and enable release
      do_tick(1'b1, 1);
      for (int i = 1; i <= WIN + 1; i++) do_tick(i == WIN + 1, 1);
      chk("R6", "latched at tick 9", oc_shutdown, 1'b1);
      chk("R6", "pgood low", pgood_pull_low, 1'b1);
      chk("R6", "inhibit", hs_inhibit, 1'b1);
      for (int i = 0; i < 4; i++) do_tick(i[0], 1);
      chk("R8", "latch holds", oc_shutdown, 1'b1);
      chk("R8", "inhibit holds", hs_inhibit, 1'b1);
      @(negedge clk); enable = 1'b0;
      settle();
      chk("R8", "enable clears latch", oc_shutdown, 1'b0);
      chk("R8", "enable clears inhibit", hs_inhibit, 1'b0);
      @(negedge clk); enable = 1'b1;

      // R6: trip on tick 16; supply release
      do_tick(1'b1, 1);
      for (int i = 1; i <= 2 * WIN; i++) do_tick(i == 2 * WIN, 1);
      chk("R6", "latched at tick 16", oc_shutdown, 1'b1);
      @(negedge clk); supply_ok = 1'b0;
      settle();
      chk("R8", "supply clears latch", oc_shutdown, 1'b0);
      @(negedge clk); supply_ok = 1'b1;

      // R8: enable drop mid-sequence
      do_tick(1'b1, 1);
      for (int i = 1; i <= WIN + 2; i++) do_tick(1'b0, 1);
      chk("R4", "in second window", win_second, 1'b1);
      @(negedge clk); enable = 1'b0;
      settle();
      chk("R8", "windows cleared", win_first | win_second, 1'b0);
      @(negedge clk); enable = 1'b1;
      do_tick(1'b0, 2);
      chk("R7", "stays idle", win_first | win_second, 1'b0);

      repeat (4) @(negedge clk);
      cmp_on = 0;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule